// File: doc/BRIEF.md
# GPIO Port Interrupt Controller

This block gives a chip three 8-bit general-purpose I/O ports on a simple synchronous register bus. Two of the ports are called A and B and the third is called F. For each port, software chooses the direction of each line. It writes the values to drive and reads back the line levels. Each line can also raise an interrupt. Two register bits per line set the trigger: one selects level or edge, and the other selects the active sense (low/falling or high/rising).

Pad inputs pass through a two-flop synchronizer. An edge is found by comparing the synchronized level with its value one cycle earlier. A matching edge is caught in a per-line latch, and software clears the latch by writing a bit mask to an acknowledge register. A per-line enable gates what reaches the status register and the interrupt outputs. Ports A and B share one OR-ed interrupt line. Port F has one interrupt output per line.

Top module: `gpio_port_irq_ctrl`

## Requirements
- R1: After reset, every register of every port reads 0, all output enables and drive values are 0, and every interrupt output is low.
- R2: A line's output enable equals its direction bit (1 = output, 0 = input), and its drive value equals the written data bit. Both change on the clock edge that takes the write.
- R3: A read of the data register returns the written data bit for output lines and the synchronized pad level for input lines. A pad change first shows on the second clock edge after it.
- R4: In level mode (trigger-kind bit 0), a status bit is its enable bit ANDed with "pad level equals sense bit" (sense 1 = high, 0 = low). A write to the acknowledge register has no effect on a line in level mode.
- R5: In edge mode (trigger-kind bit 1), a pad transition that matches the sense bit (1 = rising, 0 = falling) sets the line's latch. The status bit (enable AND latch) shows it from the third clock edge after the pad change. A transition of the other direction sets nothing.
- R6: Writing a mask to the acknowledge register clears the latch of each line whose mask bit is 1 and leaves the other latches unchanged. The acknowledge register reads as 0.
- R7: If a new matching edge reaches the latch on the same clock edge as an acknowledge write for that line, the line stays latched.
- R8: The latch keeps catching edges while the line's enable is 0. Setting the enable later shows the pending edge at once in status and on the interrupt output.
- R9: The shared A/B interrupt output is high exactly when any status bit of port A or port B is 1. Port F interrupt output i equals port F status bit i.
- R10: Register offsets are: port A: data 0x00, direction 0x10, kind 0x90, sense 0x94, acknowledge 0x98, enable 0x9C, status 0xA0. Port B: 0x04, 0x14, 0xAC, 0xB0, 0xB4, 0xB8, 0xBC. Port F: 0x30, 0x34, 0x4C, 0x50, 0x54, 0x5C, 0x58. Direction, kind, sense and enable read back what was written. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| port_a_pins | input | 8 | Port A pad levels |
| port_a_drive | output | 8 | Port A drive values |
| port_a_oe | output | 8 | Port A output enables |
| port_b_pins | input | 8 | Port B pad levels |
| port_b_drive | output | 8 | Port B drive values |
| port_b_oe | output | 8 | Port B output enables |
| port_f_pins | input | 8 | Port F pad levels |
| port_f_drive | output | 8 | Port F drive values |
| port_f_oe | output | 8 | Port F output enables |
| irq_ab | output | 1 | Shared interrupt for ports A and B |
| irq_f | output | 8 | Per-line interrupts of port F |

## Verification
The bench sweeps every port through all four trigger settings and many pad patterns and acknowledge masks, and it checks against an arithmetic model of the latches and level matches.

It aims one acknowledge write at the exact edge where a new rising edge is latched. A design that gives clearing priority would lose that interrupt.

It lets edges arrive while a line is disabled and then enables the line. A design that gates the latch with the enable would stay silent.

It also probes data reads one and two edges after a pad change, to pin down the synchronizer depth. It reads every offset, including the out-of-order status offset of port F, where a decode slip would alias another register.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int LINE_W    = 8;
  localparam int ADDR_W    = 8;
  localparam int NUM_PORTS = 3;

  typedef struct packed {
    logic [ADDR_W-1:0] data_off;
    logic [ADDR_W-1:0] dir_off;
    logic [ADDR_W-1:0] kind_off;
    logic [ADDR_W-1:0] sense_off;
    logic [ADDR_W-1:0] ack_off;
    logic [ADDR_W-1:0] en_off;
    logic [ADDR_W-1:0] stat_off;
  } port_map_t;

  // Index 0 = port A, 1 = port B, 2 = port F
  function automatic port_map_t port_map(input int idx);
    port_map_t m;
    case (idx)
      0:       m = '{8'h00, 8'h10, 8'h90, 8'h94, 8'h98, 8'h9C, 8'hA0};
      1:       m = '{8'h04, 8'h14, 8'hAC, 8'hB0, 8'hB4, 8'hB8, 8'hBC};
      default: m = '{8'h30, 8'h34, 8'h4C, 8'h50, 8'h54, 8'h5C, 8'h58};
    endcase
    return m;
  endfunction

  // Live level equals the chosen sense
  function automatic logic [LINE_W-1:0] level_hit(input logic [LINE_W-1:0] pin,
                                                  input logic [LINE_W-1:0] sense);
    return ~(pin ^ sense);
  endfunction

  // Transition in the chosen direction between two samples
  function automatic logic [LINE_W-1:0] edge_hit(input logic [LINE_W-1:0] cur,
                                                 input logic [LINE_W-1:0] prev,
                                                 input logic [LINE_W-1:0] sense);
    return (sense & cur & ~prev) | (~sense & ~cur & prev);
  endfunction

  function automatic logic [LINE_W-1:0] latch_next(input logic [LINE_W-1:0] latch,
                                                   input logic [LINE_W-1:0] kind,
                                                   input logic [LINE_W-1:0] clr,
                                                   input logic [LINE_W-1:0] evt);
    return kind & ((latch & ~clr) | evt);
  endfunction

  function automatic logic [LINE_W-1:0] line_status(input logic [LINE_W-1:0] en,
                                                    input logic [LINE_W-1:0] kind,
                                                    input logic [LINE_W-1:0] latch,
                                                    input logic [LINE_W-1:0] lvl);
    return en & ((kind & latch) | (~kind & lvl));
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpio_irq_pkg::*;
#(
  parameter port_map_t MAP = port_map(0),
  parameter int        W   = LINE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe,
  output logic [W-1:0]      status
);
  logic [W-1:0] pin_s, pin_prev;
  logic [W-1:0] out_q, dir_q, kind_q, sense_q, en_q, latch_q;
  logic [W-1:0] edge_seen, level_match, ack_mask;

  gpio_sync #(.W(W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pin_s)
  );

  logic wr_data, wr_dir, wr_kind, wr_sense, wr_ack, wr_en_reg;
  assign wr_data   = wr_en && (addr == MAP.data_off);
  assign wr_dir    = wr_en && (addr == MAP.dir_off);
  assign wr_kind   = wr_en && (addr == MAP.kind_off);
  assign wr_sense  = wr_en && (addr == MAP.sense_off);
  assign wr_ack    = wr_en && (addr == MAP.ack_off);
  assign wr_en_reg = wr_en && (addr == MAP.en_off);

  assign ack_mask    = wr_ack ? wdata : '0;
  assign edge_seen   = edge_hit(pin_s, pin_prev, sense_q) & kind_q;
  assign level_match = level_hit(pin_s, sense_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_prev <= '0;
      out_q    <= '0;
      dir_q    <= '0;
      kind_q   <= '0;
      sense_q  <= '0;
      en_q     <= '0;
      latch_q  <= '0;
    end else begin
      pin_prev <= pin_s;
      latch_q  <= latch_next(latch_q, kind_q, ack_mask, edge_seen);
      if (wr_data)   out_q   <= wdata;
      if (wr_dir)    dir_q   <= wdata;
      if (wr_kind)   kind_q  <= wdata;
      if (wr_sense)  sense_q <= wdata;
      if (wr_en_reg) en_q    <= wdata;
    end
  end

  assign status  = line_status(en_q, kind_q, latch_q, level_match);
  assign pad_out = out_q;
  assign pad_oe  = dir_q;

  always_comb begin
    rdata = '0;
    if      (addr == MAP.data_off)  rdata = (dir_q & out_q) | (~dir_q & pin_s);
    else if (addr == MAP.dir_off)   rdata = dir_q;
    else if (addr == MAP.kind_off)  rdata = kind_q;
    else if (addr == MAP.sense_off) rdata = sense_q;
    else if (addr == MAP.en_off)    rdata = en_q;
    else if (addr == MAP.stat_off)  rdata = status;
  end

  // R5
  edge_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_seen != '0) |=> ((latch_q & $past(edge_seen)) == $past(edge_seen)));

  // R5
  latch_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((latch_q & ~$past(latch_q) & ~$past(edge_seen)) == '0));

  // R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_mask != '0) |=> ((latch_q & $past(ack_mask & ~edge_seen)) == '0));

  // R2
  oe_follows_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (pad_oe == $past(wdata)));
endmodule

// File: rtl/gpio_port_irq_ctrl.sv
module gpio_port_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [LINE_W-1:0] bus_wdata,
  output logic [LINE_W-1:0] bus_rdata,
  input  logic [LINE_W-1:0] port_a_pins,
  output logic [LINE_W-1:0] port_a_drive,
  output logic [LINE_W-1:0] port_a_oe,
  input  logic [LINE_W-1:0] port_b_pins,
  output logic [LINE_W-1:0] port_b_drive,
  output logic [LINE_W-1:0] port_b_oe,
  input  logic [LINE_W-1:0] port_f_pins,
  output logic [LINE_W-1:0] port_f_drive,
  output logic [LINE_W-1:0] port_f_oe,
  output logic              irq_ab,
  output logic [LINE_W-1:0] irq_f
);
  logic [LINE_W-1:0] pin_w  [NUM_PORTS];
  logic [LINE_W-1:0] drv_w  [NUM_PORTS];
  logic [LINE_W-1:0] oe_w   [NUM_PORTS];
  logic [LINE_W-1:0] stat_w [NUM_PORTS];
  logic [LINE_W-1:0] rd_w   [NUM_PORTS];

  assign pin_w[0] = port_a_pins;
  assign pin_w[1] = port_b_pins;
  assign pin_w[2] = port_f_pins;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    gpio_port_bank #(.MAP(port_map(g)), .W(LINE_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_wr),
      .addr    (bus_addr),
      .wdata   (bus_wdata),
      .rdata   (rd_w[g]),
      .pad_in  (pin_w[g]),
      .pad_out (drv_w[g]),
      .pad_oe  (oe_w[g]),
      .status  (stat_w[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_PORTS; i++) bus_rdata = bus_rdata | rd_w[i];
  end

  assign port_a_drive = drv_w[0];
  assign port_a_oe    = oe_w[0];
  assign port_b_drive = drv_w[1];
  assign port_b_oe    = oe_w[1];
  assign port_f_drive = drv_w[2];
  assign port_f_oe    = oe_w[2];

  assign irq_ab = (|stat_w[0]) | (|stat_w[1]);
  assign irq_f  = stat_w[2];
endmodule

// File: tb/gpio_port_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_port_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pf_in = 8'h00;
  logic [7:0] pa_drv, pa_oe, pb_drv, pb_oe, pf_drv, pf_oe;
  logic       irq_ab;
  logic [7:0] irq_f;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // model state per port
  logic [7:0] m_pin [3];
  logic [7:0] m_kind [3];
  logic [7:0] m_sense [3];
  logic [7:0] m_en [3];
  logic [7:0] m_latch [3];

  always #2.5 clk = ~clk;

  gpio_port_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .port_a_pins(pa_in), .port_a_drive(pa_drv), .port_a_oe(pa_oe),
    .port_b_pins(pb_in), .port_b_drive(pb_drv), .port_b_oe(pb_oe),
    .port_f_pins(pf_in), .port_f_drive(pf_drv), .port_f_oe(pf_oe),
    .irq_ab(irq_ab), .irq_f(irq_f)
  );

  // kind: 0 data 1 dir 2 trigger-kind 3 sense 4 ack 5 enable 6 status
  function automatic logic [7:0] offs(input int p, input int k);
    logic [7:0] a [7];
    if (p == 0)      a = '{8'h00, 8'h10, 8'h90, 8'h94, 8'h98, 8'h9C, 8'hA0};
    else if (p == 1) a = '{8'h04, 8'h14, 8'hAC, 8'hB0, 8'hB4, 8'hB8, 8'hBC};
    else             a = '{8'h30, 8'h34, 8'h4C, 8'h50, 8'h54, 8'h5C, 8'h58};
    return a[k];
  endfunction

  function automatic logic [7:0] exp_stat(input int p);
    logic [7:0] lvl;
    lvl = ~(m_pin[p] ^ m_sense[p]);
    return m_en[p] & ((m_kind[p] & m_latch[p]) | (~m_kind[p] & lvl));
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wreg(input int p, input int k, input logic [7:0] v);
    wr(offs(p, k), v);
    case (k)
      2: begin m_kind[p] = v; m_latch[p] &= v; end
      3: m_sense[p] = v;
      4: m_latch[p] &= ~v;
      5: m_en[p] = v;
      default: ;
    endcase
  endtask

  task automatic drive_pins(input int p, input logic [7:0] v);
    if (p == 0) pa_in = v; else if (p == 1) pb_in = v; else pf_in = v;
  endtask

  task automatic set_pins(input int p, input logic [7:0] v);
    logic [7:0] ev;
    @(negedge clk);
    drive_pins(p, v);
    ev = (m_sense[p] & v & ~m_pin[p]) | (~m_sense[p] & ~v & m_pin[p]);
    m_latch[p] = m_kind[p] & (m_latch[p] | ev);
    m_pin[p] = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_port(input int p, input string tag);
    logic [7:0] s;
    rd(offs(p, 6), s);
    check(tag, s, exp_stat(p));
    check("R9 irq_ab", {7'b0, irq_ab}, {7'b0, (|exp_stat(0)) | (|exp_stat(1))});
    check("R9 irq_f", irq_f, exp_stat(2));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    for (int p = 0; p < 3; p++) begin
      m_pin[p] = 0; m_kind[p] = 0; m_sense[p] = 0; m_en[p] = 0; m_latch[p] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int p = 0; p < 3; p++)
      for (int k = 0; k < 7; k++) begin
        rd(offs(p, k), r);
        check("R1 reg", r, 8'h00);
      end
    check("R1 oe", pa_oe | pb_oe | pf_oe, 8'h00);
    check("R1 drive", pa_drv | pb_drv | pf_drv, 8'h00);
    check("R1 irq", irq_f | {7'b0, irq_ab}, 8'h00);

    // R10 address map readback
    for (int p = 0; p < 3; p++) begin
      logic [7:0] b;
      b = 8'(8'h21 + p * 8'h13);
      wreg(p, 1, 8'hFF);
      wreg(p, 0, b ^ 8'h5A);
      rd(offs(p, 0), r); check("R10 data", r, b ^ 8'h5A);
      wreg(p, 2, b);          rd(offs(p, 2), r); check("R10 kind", r, b);
      wreg(p, 3, ~b);         rd(offs(p, 3), r); check("R10 sense", r, ~b);
      wreg(p, 5, b ^ 8'h0F);  rd(offs(p, 5), r); check("R10 enable", r, b ^ 8'h0F);
      rd(offs(p, 1), r); check("R10 dir", r, 8'hFF);
      rd(offs(p, 4), r); check("R6 ack reads 0", r, 8'h00);
      wreg(p, 5, 8'h00); wreg(p, 2, 8'h00); wreg(p, 3, 8'h00);
      wreg(p, 1, 8'h00); wreg(p, 0, 8'h00);
    end
    rd(8'hFC, r); check("R10 unmapped", r, 8'h00);

    // R2 / R3 on port B
    wreg(1, 1, 8'h0F);
    wreg(1, 0, 8'hA5);
    check("R2 oe", pb_oe, 8'h0F);
    check("R2 drive", pb_drv, 8'hA5);
    set_pins(1, 8'h3C);
    rd(offs(1, 0), r); check("R3 data mix", r, 8'h35);
    @(negedge clk); pb_in = 8'hFF; m_pin[1] = 8'hFF;
    @(negedge clk); #1 check("R3 one edge old", bus_rdata, 8'h35);
    @(negedge clk); #1 check("R3 two edges new", bus_rdata, 8'hF5);
    wreg(1, 1, 8'h00); wreg(1, 0, 8'h00);
    set_pins(1, 8'h00);

    // sweep: every port, every trigger setting, many pad patterns
    for (int p = 0; p < 3; p++)
      for (int m = 0; m < 4; m++) begin
        logic [7:0] kv, sv, ev;
        kv = m[1] ? 8'hFF : 8'h00;
        sv = m[0] ? 8'hFF : 8'h00;
        ev = 8'hFF ^ (8'h01 << (m * 2));
        wreg(p, 5, 8'h00);
        wreg(p, 2, kv);
        wreg(p, 3, sv);
        wreg(p, 4, 8'hFF);
        wreg(p, 5, ev);
        for (int k = 0; k < 16; k++) begin
          logic [7:0] nv, mk;
          nv = 8'(k * 107) ^ 8'(k << 4);
          mk = 8'(k * 41 + 3);
          set_pins(p, nv);
          check_port(p, m[1] ? "R5 edge" : "R4 level");
          wreg(p, 4, mk);
          check_port(p, m[1] ? "R6 ack mask" : "R4 ack ignored");
        end
        wreg(p, 5, 8'h00);
        set_pins(p, 8'h00);
        wreg(p, 4, 8'hFF);
      end

    // R7 edge and acknowledge on the same clock edge (port A, rising)
    wreg(0, 2, 8'hFF); wreg(0, 3, 8'hFF); wreg(0, 4, 8'hFF); wreg(0, 5, 8'hFF);
    set_pins(0, 8'h00);
    set_pins(0, 8'h03);
    check_port(0, "R5 rising latched");
    set_pins(0, 8'h00);
    check_port(0, "R5 falling ignored");
    @(negedge clk); pa_in = 8'h01;
    @(negedge clk);
    @(negedge clk); bus_wr = 1'b1; bus_addr = offs(0, 4); bus_wdata = 8'h03;
    @(negedge clk); bus_wr = 1'b0;
    m_pin[0] = 8'h01; m_latch[0] = 8'h01;
    rd(offs(0, 6), r); check("R7 collide", r, 8'h01);
    check_port(0, "R7 collide");
    wreg(0, 5, 8'h00); wreg(0, 4, 8'hFF);

    // R8 latch while disabled (port F, falling)
    wreg(2, 2, 8'hFF); wreg(2, 3, 8'h00); wreg(2, 4, 8'hFF); wreg(2, 5, 8'h00);
    set_pins(2, 8'hFF);
    set_pins(2, 8'h00);
    check_port(2, "R8 disabled quiet");
    check("R8 irq_f quiet", irq_f, 8'h00);
    wreg(2, 5, 8'h0F);
    check_port(2, "R8 pending shown");
    check("R8 irq_f pending", irq_f, 8'h0F);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule